// File: doc/BRIEF.md
# Windowed Watchdog Timer with Boot-Time Option Word

This block is a watchdog that must be serviced inside a time window, not just before a deadline. At the first clock edge after reset it captures a 32-bit option word. The word sets the timeout length, the prescaler ratio, where the refresh window opens and closes, and whether a fault produces a reset request or a non-maskable interrupt request. In boot mode the supplied word is ignored and the erased value (all ones) is used instead.

A free-running prescaler produces count ticks, and each tick decrements the down-counter. A refresh strobe reloads the counter, but only while the count is inside the window. Two events count as a fault: a refresh outside the window, and the counter underflowing. On either fault the counter reloads and keeps running. A reset response is a one-cycle pulse. An NMI response stays high until the clear input is raised.

Two scaling parameters shorten every timeout and divide ratio by a power of two. Their default of zero gives the full-length periods.

Top module: `winwdt`

## Requirements
- R1: The option word is captured at the first rising clock edge after reset, and the counting state is loaded at that same edge. While `boot_mode_i` is high, the word used is all ones, whatever `opt_word_i` carries.
- R2: Bits [19:18] select the timeout T: 00 gives 1024, 01 gives 4096, 10 gives 8192, 11 gives 16384, each divided by 2^CNT_SHIFT. The reload value is T-1, and `count_o` shows it once the counter is loaded.
- R3: Bits [23:20] select the divide ratio: 0001 is 4, 0100 is 64, 1111 is 128, 0110 is 512, 0111 is 2048 and 1000 is 8192. Each is divided by 2^DIV_SHIFT, with a floor of 1. The counter decreases by exactly one every ratio clocks, starting from the load.
- R4: Any other ratio code, with auto-start high, raises `cfg_err_o`. The counter then never runs, and `count_o` stays 0.
- R5: With `auto_start_i` low at capture, the block stays stopped. `count_o` remains 0, and refresh pulses set no flag and raise no request.
- R6: When the count is 0, the next tick is an underflow. It sets `uflow_flag_o` and reloads the count to T-1. The fault therefore occurs T×ratio clocks after a load.
- R7: A refresh is accepted only when two conditions hold. First, count ≤ (T/4)·S−1, where S is 1, 2, 3 or 4 for start codes 00, 01, 10, 11 in bits [27:26]. Second, count > (T/4)·E−1, where E is 3, 2, 1 or 0 for end codes 00, 01, 10, 11 in bits [25:24]; E=0 removes the end limit. An accepted refresh reloads the count to T-1 and raises nothing.
- R8: A refresh outside the window is a fault. It sets `refresh_err_o` and reloads the count to T-1.
- R9: Bit 28 selects the fault response. When it is 1, `rst_req_o` pulses for one cycle. When it is 0, `nmi_req_o` rises and stays high until `clear_i`.
- R10: `clear_i` clears `nmi_req_o`, `uflow_flag_o` and `refresh_err_o`. A fault in the same cycle takes priority over the clear.
- R11: While reset is asserted, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| opt_word_i | input | 32 | Non-volatile option word |
| boot_mode_i | input | 1 | Boot mode: use the all-ones word |
| auto_start_i | input | 1 | Start counting after reset |
| refresh_i | input | 1 | Refresh strobe |
| clear_i | input | 1 | Clear the NMI request and the fault flags |
| rst_req_o | output | 1 | One-cycle reset request |
| nmi_req_o | output | 1 | Sticky NMI request |
| count_o | output | 14-CNT_SHIFT | Down-counter value |
| running_o | output | 1 | Counter running |
| uflow_flag_o | output | 1 | Underflow occurred |
| refresh_err_o | output | 1 | Refresh outside the window occurred |
| cfg_err_o | output | 1 | Prohibited prescaler code |

## Verification
The bench builds the block with CNT_SHIFT=4 and DIV_SHIFT=6. Timeouts become 64 to 1024 counts, and divide ratios become 1, 1, 2, 8, 32 and 128. With these values a complete underflow, and refreshes at every point of the window, fit in a few thousand cycles. Each window boundary can then be hit exactly, and many random configurations can be run back to back.

// File: rtl/winwdt_pkg.sv
package winwdt_pkg;

    typedef enum logic {
        RESP_NMI = 1'b0,
        RESP_RST = 1'b1
    } resp_e;

    // log2 of the timeout length from the period selector
    function automatic logic [3:0] tout_log2(input logic [1:0] sel);
        case (sel)
            2'b00:   return 4'd10;
            2'b01:   return 4'd12;
            2'b10:   return 4'd13;
            default: return 4'd14;
        endcase
    endfunction

    // {legal, log2 ratio} from the prescaler code
    function automatic logic [4:0] div_log2(input logic [3:0] code);
        case (code)
            4'b0001: return {1'b1, 4'd2};
            4'b0100: return {1'b1, 4'd6};
            4'b1111: return {1'b1, 4'd7};
            4'b0110: return {1'b1, 4'd9};
            4'b0111: return {1'b1, 4'd11};
            4'b1000: return {1'b1, 4'd13};
            default: return 5'd0;
        endcase
    endfunction

    // window opening, in quarters of the timeout
    function automatic logic [2:0] start_quarters(input logic [1:0] code);
        return {1'b0, code} + 3'd1;
    endfunction

    // window closing, in quarters of the timeout (0 = no limit)
    function automatic logic [2:0] end_quarters(input logic [1:0] code);
        return 3'd3 - {1'b0, code};
    endfunction

endpackage

// File: rtl/winwdt_decode.sv
module winwdt_decode
    import winwdt_pkg::*;
#(
    parameter int CNT_SHIFT = 0,
    parameter int DIV_SHIFT = 0,
    parameter int CNT_W     = 14,
    parameter int PRE_W     = 14
) (
    input  logic [10:0]      fld_i,      // option bits [28:18]
    output logic [CNT_W-1:0] reload_o,
    output logic [CNT_W:0]   start_lim_o,
    output logic [CNT_W:0]   end_lim_o,
    output logic             end_none_o,
    output logic [PRE_W-1:0] pre_lim_o,
    output logic             legal_o,
    output resp_e            resp_o
);
    int             tsh;
    int             dsh;
    logic [CNT_W:0] full;
    logic [CNT_W:0] qtr;
    logic [2:0]     eq;
    logic [4:0]     dv;

    always_comb begin
        tsh         = int'(tout_log2(fld_i[1:0])) - CNT_SHIFT;
        full        = (CNT_W+1)'(1) << tsh;
        reload_o    = CNT_W'(full - (CNT_W+1)'(1));
        qtr         = full >> 2;
        start_lim_o = qtr * (CNT_W+1)'(start_quarters(fld_i[9:8])) - (CNT_W+1)'(1);
        eq          = end_quarters(fld_i[7:6]);
        end_none_o  = (eq == 3'd0);
        end_lim_o   = qtr * (CNT_W+1)'(eq) - (CNT_W+1)'(1);
        dv          = div_log2(fld_i[5:2]);
        legal_o     = dv[4];
        dsh         = int'(dv[3:0]) - DIV_SHIFT;
        if (dsh < 0) dsh = 0;
        pre_lim_o   = PRE_W'((32'd1 << dsh) - 32'd1);
        resp_o      = resp_e'(fld_i[10]);
    end
endmodule

// File: rtl/winwdt_prescale.sv
module winwdt_prescale #(
    parameter int PRE_W = 14
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             en_i,
    input  logic             clr_i,
    input  logic [PRE_W-1:0] lim_i,
    output logic             tick_o
);
    typedef struct packed {
        logic [PRE_W-1:0] cnt;
    } pre_t;

    pre_t pre_d, pre_q;

    always_comb begin
        tick_o  = en_i && (pre_q.cnt == lim_i);
        pre_d   = pre_q;
        if (!en_i || clr_i || tick_o) pre_d.cnt = '0;
        else                           pre_d.cnt = pre_q.cnt + PRE_W'(1);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pre_q <= '0;
        else         pre_q <= pre_d;
    end
endmodule

// File: rtl/winwdt.sv
module winwdt
    import winwdt_pkg::*;
#(
    parameter int CNT_SHIFT = 0,
    parameter int DIV_SHIFT = 0,
    localparam int CNT_W    = 14 - CNT_SHIFT,
    localparam int PRE_W    = 14 - DIV_SHIFT
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [31:0]      opt_word_i,
    input  logic             boot_mode_i,
    input  logic             auto_start_i,
    input  logic             refresh_i,
    input  logic             clear_i,
    output logic             rst_req_o,
    output logic             nmi_req_o,
    output logic [CNT_W-1:0] count_o,
    output logic             running_o,
    output logic             uflow_flag_o,
    output logic             refresh_err_o,
    output logic             cfg_err_o
);
    typedef struct packed {
        logic             ld;
        logic             run;
        logic             cfgerr;
        logic [10:0]      cfg;
        logic [CNT_W-1:0] cnt;
        logic             rstp;
        logic             nmi;
        logic             uf;
        logic             re;
    } state_t;

    state_t st_d, st_q;

    logic [10:0]      eff_fld;
    logic [10:0]      dec_fld;
    logic [CNT_W-1:0] dec_reload;
    logic [CNT_W:0]   start_lim;
    logic [CNT_W:0]   end_lim;
    logic             end_none;
    logic [PRE_W-1:0] pre_lim;
    logic             legal;
    resp_e            resp;
    logic             tick;
    logic             pre_clr;
    logic             in_win;
    logic             bad_ref;
    logic             uflow;
    logic             unused_bits;

    assign unused_bits = ^{opt_word_i[31:29], opt_word_i[17:0]};
    assign eff_fld     = boot_mode_i ? 11'h7FF : opt_word_i[28:18];
    assign dec_fld     = st_q.ld ? st_q.cfg : eff_fld;

    winwdt_decode #(
        .CNT_SHIFT (CNT_SHIFT),
        .DIV_SHIFT (DIV_SHIFT),
        .CNT_W     (CNT_W),
        .PRE_W     (PRE_W)
    ) u_decode (
        .fld_i       (dec_fld),
        .reload_o    (dec_reload),
        .start_lim_o (start_lim),
        .end_lim_o   (end_lim),
        .end_none_o  (end_none),
        .pre_lim_o   (pre_lim),
        .legal_o     (legal),
        .resp_o      (resp)
    );

    winwdt_prescale #(.PRE_W(PRE_W)) u_prescale (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .en_i   (st_q.run),
        .clr_i  (pre_clr),
        .lim_i  (pre_lim),
        .tick_o (tick)
    );

    always_comb begin
        st_d    = st_q;
        st_d.rstp = 1'b0;
        in_win  = 1'b0;
        bad_ref = 1'b0;
        uflow   = 1'b0;
        pre_clr = 1'b0;

        if (!st_q.ld) begin
            st_d.ld     = 1'b1;
            st_d.cfg    = eff_fld;
            st_d.run    = auto_start_i && legal;
            st_d.cfgerr = auto_start_i && !legal;
            st_d.cnt    = (auto_start_i && legal) ? dec_reload : '0;
        end else if (st_q.run) begin
            in_win  = ({1'b0, st_q.cnt} <= start_lim) &&
                      (end_none || ({1'b0, st_q.cnt} > end_lim));
            bad_ref = refresh_i && !in_win;
            uflow   = !refresh_i && tick && (st_q.cnt == '0);
            pre_clr = refresh_i || uflow;
            if (refresh_i || uflow) st_d.cnt = dec_reload;
            else if (tick)          st_d.cnt = st_q.cnt - CNT_W'(1);
        end

        if (clear_i) begin
            st_d.nmi = 1'b0;
            st_d.uf  = 1'b0;
            st_d.re  = 1'b0;
        end
        if (uflow)   st_d.uf = 1'b1;
        if (bad_ref) st_d.re = 1'b1;
        if (uflow || bad_ref) begin
            if (resp == RESP_RST) st_d.rstp = 1'b1;
            else                  st_d.nmi  = 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign rst_req_o     = st_q.rstp;
    assign nmi_req_o     = st_q.nmi;
    assign count_o       = st_q.cnt;
    assign running_o     = st_q.run;
    assign uflow_flag_o  = st_q.uf;
    assign refresh_err_o = st_q.re;
    assign cfg_err_o     = st_q.cfgerr;
endmodule

// File: rtl/winwdt_chk.sv
module winwdt_chk #(
    parameter int CNT_W = 14
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             clear_i,
    input logic             rst_req_o,
    input logic             nmi_req_o,
    input logic [CNT_W-1:0] count_o,
    input logic             running_o,
    input logic             cfg_err_o,
    input logic [CNT_W-1:0] reload
);
    p_nmi_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        nmi_req_o && !clear_i |=> nmi_req_o);

    p_single_resp_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(rst_req_o && nmi_req_o));

    p_reload_on_fault_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rst_req_o |-> count_o == reload);

    p_stopped_on_bad_code_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cfg_err_o |-> !running_o && count_o == '0);

    p_single_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        running_o && $past(running_o) && count_o != reload |->
            count_o == $past(count_o) || count_o == ($past(count_o) - CNT_W'(1)));
endmodule

bind winwdt winwdt_chk #(.CNT_W(CNT_W)) u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clear_i   (clear_i),
    .rst_req_o (rst_req_o),
    .nmi_req_o (nmi_req_o),
    .count_o   (count_o),
    .running_o (running_o),
    .cfg_err_o (cfg_err_o),
    .reload    (dec_reload)
);

// File: tb/winwdt_bench.sv
module winwdt_bench;
    localparam int CLK_P = 10;
    localparam int CS    = 4;
    localparam int DS    = 6;
    localparam int CW    = 14 - CS;

    logic          clk = 1'b0;
    logic          rst_ni = 1'b0;
    logic [31:0]   opt_word = '1;
    logic          boot = 1'b0;
    logic          auto_st = 1'b1;
    logic          refresh = 1'b0;
    logic          clr = 1'b0;
    logic          rst_req, nmi_req, running, uf, re, cfgerr;
    logic [CW-1:0] count;

    int total = 0;
    int bad   = 0;

    always #(CLK_P/2) clk = ~clk;

    winwdt #(.CNT_SHIFT(CS), .DIV_SHIFT(DS)) u_winwdt (
        .clk_i (clk), .rst_ni (rst_ni), .opt_word_i (opt_word),
        .boot_mode_i (boot), .auto_start_i (auto_st), .refresh_i (refresh),
        .clear_i (clr), .rst_req_o (rst_req), .nmi_req_o (nmi_req),
        .count_o (count), .running_o (running), .uflow_flag_o (uf),
        .refresh_err_o (re), .cfg_err_o (cfgerr)
    );

    function automatic int exp_reload(input int tsel);
        int l;
        case (tsel)
            0: l = 10;
            1: l = 12;
            2: l = 13;
            default: l = 14;
        endcase
        return (1 << (l - CS)) - 1;
    endfunction

    function automatic int exp_ratio(input int dc);
        int l;
        case (dc)
            4'b0001: l = 2;
            4'b0100: l = 6;
            4'b1111: l = 7;
            4'b0110: l = 9;
            4'b0111: l = 11;
            default: l = 13;
        endcase
        l = l - DS;
        if (l < 0) l = 0;
        return 1 << l;
    endfunction

    function automatic logic [31:0] mk(input int tsel, input int dc, input int ec,
                                        input int sc, input int rs);
        return {3'b111, 1'(rs), 2'(sc), 2'(ec), 4'(dc), 2'(tsel), 18'h0};
    endfunction

    function automatic bit window_ok(input int c, input int rl, input int ec, input int sc);
        int qt;
        qt = (rl + 1) / 4;
        if (c > qt * (sc + 1) - 1) return 1'b0;
        if (ec == 3) return 1'b1;
        return c > qt * (3 - ec) - 1;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic load(input logic [31:0] w, input logic b, input logic a);
        rst_ni   = 1'b0;
        opt_word = w;
        boot     = b;
        auto_st  = a;
        repeat (2) @(negedge clk);
        rst_ni = 1'b1;
        @(negedge clk);
    endtask

    task automatic pulse_refresh();
        refresh = 1'b1;
        @(negedge clk);
        refresh = 1'b0;
    endtask

    task automatic pulse_clear();
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
    endtask

    initial begin
        #(CLK_P * 200000);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int seed;
        seed = $urandom(32'h5EED1234);

        // R11: reset state
        repeat (2) @(negedge clk);
        chk({rst_req, nmi_req, running, uf, re, cfgerr} == 6'b0 && count == 0,
            "R11 reset outputs", int'(count), 0);

        // R1: boot mode forces the all-ones word (T=1024 -> 1023, ratio 2, full window)
        load(mk(0, 4'b0100, 0, 0, 0), 1'b1, 1'b1);
        chk(count == CW'(1023), "R1 boot reload", int'(count), 1023);
        repeat (10) @(negedge clk);
        chk(count == CW'(1018), "R3 boot ratio 2", int'(count), 1018);
        pulse_refresh();
        chk(count == CW'(1023) && !re && !rst_req, "R7 boot full window", int'(count), 1023);

        // R5: stopped when auto-start is low
        load(mk(0, 4'b0001, 0, 0, 1), 1'b0, 1'b0);
        repeat (50) @(negedge clk);
        pulse_refresh();
        repeat (2) @(negedge clk);
        chk(count == 0 && !running && !re && !rst_req && !nmi_req,
            "R5 stopped ignores refresh", int'(count), 0);

        // R4: prohibited ratio code
        load(mk(0, 4'b0010, 0, 0, 1), 1'b0, 1'b1);
        repeat (20) @(negedge clk);
        chk(cfgerr && !running && count == 0, "R4 bad code", int'(cfgerr), 1);

        // R6/R9: underflow with reset response, ratio 1, reload 63
        load(mk(0, 4'b0001, 3, 3, 1), 1'b0, 1'b1);
        chk(count == CW'(63), "R2 reload 63", int'(count), 63);
        repeat (63) @(negedge clk);
        chk(count == 0 && !rst_req, "R6 count at zero", int'(count), 0);
        @(negedge clk);
        chk(rst_req && uf && count == CW'(63), "R6 underflow reload", int'(count), 63);
        chk(rst_req && !nmi_req, "R9 reset pulse high", int'(rst_req), 1);
        @(negedge clk);
        chk(!rst_req, "R9 reset pulse one cycle", int'(rst_req), 0);
        pulse_clear();
        chk(!uf, "R10 clear flag", int'(uf), 0);

        // R9/R10: underflow with NMI response, ratio 2
        load(mk(0, 4'b1111, 3, 3, 0), 1'b0, 1'b1);
        repeat (127) @(negedge clk);
        chk(count == 0 && !nmi_req, "R6 ratio 2 before fault", int'(count), 0);
        @(negedge clk);
        chk(nmi_req && !rst_req && count == CW'(63), "R9 nmi raised", int'(nmi_req), 1);
        repeat (5) @(negedge clk);
        chk(nmi_req, "R9 nmi held", int'(nmi_req), 1);
        pulse_clear();
        chk(!nmi_req, "R10 nmi cleared", int'(nmi_req), 0);

        // R7/R8: window boundaries, start 50% (lim 31), end 25% (lim 15)
        begin
            int ks[4]  = '{32, 31, 47, 48};
            int cs[4]  = '{31, 32, 16, 15};
            bit acc[4] = '{1'b1, 1'b0, 1'b1, 1'b0};
            for (int i = 0; i < 4; i++) begin
                load(mk(0, 4'b0001, 2, 1, 0), 1'b0, 1'b1);
                repeat (ks[i]) @(negedge clk);
                chk(count == CW'(cs[i]), "R3 window approach", int'(count), cs[i]);
                pulse_refresh();
                if (acc[i]) chk(!re && !nmi_req && count == CW'(63), "R7 edge accepted", int'(re), 0);
                else        chk(re && nmi_req && count == CW'(63), "R8 edge rejected", int'(re), 1);
            end
        end

        // R2/R3/R7/R8/R9: random configurations
        for (int t = 0; t < 24; t++) begin
            int dcs[4] = '{4'b0001, 4'b0100, 4'b1111, 4'b0110};
            int tsel, dc, ec, sc, rs, rl, r, k, c;
            bit ok;
            dc   = dcs[$urandom % 4];
            tsel = (dc == 4'b0110) ? int'($urandom % 2) : int'($urandom % 4);
            ec   = $urandom % 4;
            sc   = $urandom % 4;
            rs   = $urandom % 2;
            rl   = exp_reload(tsel);
            r    = exp_ratio(dc);
            k    = $urandom % (rl * r);
            load(mk(tsel, dc, ec, sc, rs), 1'b0, 1'b1);
            repeat (k) @(negedge clk);
            chk(count == CW'(rl - k / r), "R3 random countdown", int'(count), rl - k / r);
            c  = int'(count);
            ok = window_ok(c, rl, ec, sc);
            pulse_refresh();
            chk(count == CW'(rl), "R2 reload after refresh", int'(count), rl);
            if (ok) chk(!re && !rst_req && !nmi_req, "R7 random accepted", int'(re), 0);
            else if (rs == 1) chk(re && rst_req && !nmi_req, "R8 R9 random reject reset", int'(rst_req), 1);
            else chk(re && nmi_req && !rst_req, "R8 R9 random reject nmi", int'(nmi_req), 1);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule